// File: doc/BRIEF.md
# 100 Mb/s Code-Group Receive Decoder

This block is the receive half of a 100 Mb/s physical coding sublayer. Each clock it takes one already aligned, descrambled 5-bit code group. It looks for the two-symbol start-of-stream delimiter and turns the data code groups that follow into 4-bit nibbles on an MII-style receive port: a data nibble, a data-valid strobe and an error strobe. The two-symbol end-of-stream delimiter closes the frame and never reaches the nibble port.

The decoder works on a window of two symbols: the symbol held from the previous clock and the symbol now at the input. This lets it confirm both halves of a delimiter before it commits any output. Two line conditions are caught and kept in separate latched status bits until a clear pulse arrives: false carrier, which is activity that does not resolve into a start delimiter, and premature end, which is a pair of idles inside a frame.

Top module: `pcs_rx_decoder`

## Requirements
- R1: While reset is held and right after it, rx_dv_o, rx_er_o and rxd_o are 0, and both status bits are 0.
- R2: Inside a frame, data code groups decode as 11110→0, 01001→1, 10100→2, 10101→3, 01010→4, 01011→5, 01110→6, 01111→7, 10010→8, 10011→9, 10110→A, 10111→B, 11010→C, 11011→D, 11100→E, 11101→F, each with rx_dv_o=1 and rx_er_o=0.
- R3: A start delimiter, 11000 followed at once by 10001, yields two nibbles of 0101 with rx_dv_o=1, and then the frame data.
- R4: Between frames the idle code group 11111 gives rx_dv_o=0, rx_er_o=0 and rxd_o=0000.
- R5: An end delimiter, 01101 followed at once by 00111, ends the frame. Both of its symbols give rx_dv_o=0 and rx_er_o=0, and a new start delimiter may follow directly.
- R6: Inside a frame, a code group that is not data (an invalid group, a single idle, a start symbol, or 01101 not followed by 00111) gives rx_dv_o=1, rx_er_o=1 and rxd_o=0000, and the frame continues.
- R7: Outside a frame, a non-idle code group that does not begin a valid start delimiter is false carrier. From that symbol until an idle is seen, the outputs are rx_dv_o=0, rx_er_o=1 and rxd_o=1110, and false_carrier_o is set.
- R8: Two idles in a row inside a frame are a premature end. The first idle gives rx_dv_o=0, rx_er_o=1 and rxd_o=0000, the frame closes, and premature_end_o is set.
- R9: Each status bit stays at 1 until a one-cycle stat_clr_i pulse clears it. If an event and the clear fall on the same edge, the bit stays at 1.
- R10: The output for a code group appears after the second rising edge that follows the clock cycle in which the group is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Symbol clock |
| rst_n | input | 1 | Active-low synchronous reset |
| code_i | input | SYM_W | Aligned code group, one per clock |
| stat_clr_i | input | 1 | One-cycle clear of both status bits |
| rxd_o | output | NIB_W | Received nibble |
| rx_dv_o | output | 1 | Receive data valid |
| rx_er_o | output | 1 | Receive error |
| false_carrier_o | output | 1 | Latched false-carrier status |
| premature_end_o | output | 1 | Latched premature-end status |

## Verification
Two functions can land on the same edge: the clear of a status bit and a fresh false-carrier event. The bench first clears the bit, then presents an invalid code group outside a frame, and pulses stat_clr_i with the next symbol. That places the clear on the same edge where the decoder reports the event. The bench judges the result by reading false_carrier_o afterwards, which must be 1, while premature_end_o, which saw only the clear, must be 0.

// File: rtl/pcs_rx_pkg.sv
package pcs_rx_pkg;

   localparam int SYM_W = 5;
   localparam int NIB_W = 4;

   typedef logic [SYM_W-1:0] sym_t;
   typedef logic [NIB_W-1:0] nib_t;

   localparam sym_t SYM_IDLE  = 5'b11111;
   localparam sym_t SYM_SSD_A = 5'b11000;
   localparam sym_t SYM_SSD_B = 5'b10001;
   localparam sym_t SYM_ESD_A = 5'b01101;
   localparam sym_t SYM_ESD_B = 5'b00111;

   localparam nib_t NIB_PREAMBLE = 4'b0101;
   localparam nib_t NIB_FALSE_CAR = 4'b1110;

   localparam int FLAG_FALSE_CAR = 0;
   localparam int FLAG_PREM_END = 1;
   localparam int NUM_FLAGS = 2;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_SSD,
      ST_RECV,
      ST_ESD,
      ST_FCAR
   } rx_state_e;

   typedef struct packed {
      logic dv;
      logic er;
      nib_t d;
   } mii_rx_t;

   typedef struct packed {
      logic is_data;
      logic is_idle;
      logic is_ssd_a;
      logic is_esd_a;
      nib_t nib;
   } sym_info_t;

endpackage

// File: rtl/pcs_sym_decode.sv
module pcs_sym_decode
   import pcs_rx_pkg::*;
(
   input  sym_t      sym_i,
   output sym_info_t info_o
);

   always_comb begin
      info_o          = '0;
      info_o.is_data  = 1'b1;
      unique case (sym_i)
         5'b11110: info_o.nib = 4'h0;
         5'b01001: info_o.nib = 4'h1;
         5'b10100: info_o.nib = 4'h2;
         5'b10101: info_o.nib = 4'h3;
         5'b01010: info_o.nib = 4'h4;
         5'b01011: info_o.nib = 4'h5;
         5'b01110: info_o.nib = 4'h6;
         5'b01111: info_o.nib = 4'h7;
         5'b10010: info_o.nib = 4'h8;
         5'b10011: info_o.nib = 4'h9;
         5'b10110: info_o.nib = 4'hA;
         5'b10111: info_o.nib = 4'hB;
         5'b11010: info_o.nib = 4'hC;
         5'b11011: info_o.nib = 4'hD;
         5'b11100: info_o.nib = 4'hE;
         5'b11101: info_o.nib = 4'hF;
         default: info_o.is_data = 1'b0;
      endcase
      info_o.is_idle  = (sym_i == SYM_IDLE);
      info_o.is_ssd_a = (sym_i == SYM_SSD_A);
      info_o.is_esd_a = (sym_i == SYM_ESD_A);
   end

endmodule

// File: rtl/pcs_sticky_flag.sv
module pcs_sticky_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   output logic flag_o
);

   always_ff @(posedge clk) begin
      if (!rst_n)
         flag_o <= 1'b0;
      else if (set_i)
         flag_o <= 1'b1;
      else if (clr_i)
         flag_o <= 1'b0;
   end

   AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      set_i |=> flag_o); // R9
   AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_o && !clr_i) |=> flag_o); // R9
   AST_FLAG_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i && !set_i) |=> !flag_o); // R9

endmodule

// File: rtl/pcs_rx_fsm.sv
module pcs_rx_fsm
   import pcs_rx_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  sym_info_t prev_i,
   input  sym_t      cur_i,
   output mii_rx_t   mii_o,
   output logic      false_car_o,
   output logic      prem_end_o
);

   rx_state_e state_q, state_d;
   mii_rx_t   mii_d;

   always_comb begin
      state_d     = state_q;
      mii_d       = '0;
      false_car_o = 1'b0;
      prem_end_o  = 1'b0;
      unique case (state_q)
         ST_IDLE: begin
            if (prev_i.is_idle) begin
               state_d = ST_IDLE;
            end else if (prev_i.is_ssd_a && cur_i == SYM_SSD_B) begin
               mii_d.dv = 1'b1;
               mii_d.d  = NIB_PREAMBLE;
               state_d  = ST_SSD;
            end else begin
               false_car_o = 1'b1;
               mii_d.er    = 1'b1;
               mii_d.d     = NIB_FALSE_CAR;
               state_d     = ST_FCAR;
            end
         end
         ST_SSD: begin
            mii_d.dv = 1'b1;
            mii_d.d  = NIB_PREAMBLE;
            state_d  = ST_RECV;
         end
         ST_RECV: begin
            if (prev_i.is_esd_a && cur_i == SYM_ESD_B) begin
               state_d = ST_ESD;
            end else if (prev_i.is_idle && cur_i == SYM_IDLE) begin
               prem_end_o = 1'b1;
               mii_d.er   = 1'b1;
               state_d    = ST_IDLE;
            end else if (prev_i.is_data) begin
               mii_d.dv = 1'b1;
               mii_d.d  = prev_i.nib;
            end else begin
               mii_d.dv = 1'b1;
               mii_d.er = 1'b1;
            end
         end
         ST_ESD: begin
            state_d = ST_IDLE;
         end
         ST_FCAR: begin
            if (prev_i.is_idle) begin
               state_d = ST_IDLE;
            end else begin
               mii_d.er = 1'b1;
               mii_d.d  = NIB_FALSE_CAR;
            end
         end
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         mii_o   <= '0;
      end else begin
         state_q <= state_d;
         mii_o   <= mii_d;
      end
   end

   AST_PREAMBLE_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mii_o.dv) |-> (mii_o.d == NIB_PREAMBLE)); // R3
   AST_PREAMBLE_SECOND: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mii_o.dv) |=> (mii_o.dv && mii_o.d == NIB_PREAMBLE)); // R3
   AST_ESD_HIDDEN: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_RECV && prev_i.is_esd_a && cur_i == SYM_ESD_B)
      |=> (!mii_o.dv && !mii_o.er)); // R5
   AST_FALSE_CAR_OUT: assert property (@(posedge clk) disable iff (!rst_n)
      false_car_o |=> (!mii_o.dv && mii_o.er)); // R7
   AST_PREM_END_OUT: assert property (@(posedge clk) disable iff (!rst_n)
      prem_end_o |=> (!mii_o.dv && mii_o.er)); // R8

endmodule

// File: rtl/pcs_rx_decoder.sv
module pcs_rx_decoder
   import pcs_rx_pkg::*;
#(
   parameter int SYM_W = pcs_rx_pkg::SYM_W,
   parameter int NIB_W = pcs_rx_pkg::NIB_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [SYM_W-1:0] code_i,
   input  logic             stat_clr_i,
   output logic [NIB_W-1:0] rxd_o,
   output logic             rx_dv_o,
   output logic             rx_er_o,
   output logic             false_carrier_o,
   output logic             premature_end_o
);

   initial begin
      if (SYM_W != 5 || NIB_W != 4)
         $fatal(1, "code group and nibble widths must be 5 and 4");
   end

   sym_t                 cur_sym;
   sym_t                 prev_sym_q;
   sym_info_t            prev_info;
   mii_rx_t              mii;
   logic [NUM_FLAGS-1:0] flag_set;
   logic [NUM_FLAGS-1:0] flag_q;

   assign cur_sym = sym_t'(code_i);

   // one-symbol lookahead window: held symbol plus current input
   always_ff @(posedge clk) begin
      if (!rst_n)
         prev_sym_q <= SYM_IDLE;
      else
         prev_sym_q <= cur_sym;
   end

   pcs_sym_decode u_decode (
      .sym_i  (prev_sym_q),
      .info_o (prev_info)
   );

   pcs_rx_fsm u_fsm (
      .clk         (clk),
      .rst_n       (rst_n),
      .prev_i      (prev_info),
      .cur_i       (cur_sym),
      .mii_o       (mii),
      .false_car_o (flag_set[FLAG_FALSE_CAR]),
      .prem_end_o  (flag_set[FLAG_PREM_END])
   );

   for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_flag
      pcs_sticky_flag u_flag (
         .clk    (clk),
         .rst_n  (rst_n),
         .set_i  (flag_set[g]),
         .clr_i  (stat_clr_i),
         .flag_o (flag_q[g])
      );
   end

   assign rxd_o           = NIB_W'(mii.d);
   assign rx_dv_o         = mii.dv;
   assign rx_er_o         = mii.er;
   assign false_carrier_o = flag_q[FLAG_FALSE_CAR];
   assign premature_end_o = flag_q[FLAG_PREM_END];

endmodule

// File: tb/test_pcs_rx_decoder.sv
module test_pcs_rx_decoder;

   typedef struct {
      logic       dv;
      logic       er;
      logic [3:0] d;
      string      tag;
   } exp_t;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [4:0] code = 5'b11111;
   logic       clr = 1'b0;
   logic [3:0] rxd;
   logic       dv, er, fc, pe;
   logic       mon_en = 1'b0;
   int         n_checks = 0;
   int         n_errors = 0;
   exp_t       q[$];

   always #10 clk = ~clk;

   pcs_rx_decoder i_pcs_rx_decoder (
      .clk             (clk),
      .rst_n           (rst_n),
      .code_i          (code),
      .stat_clr_i      (clr),
      .rxd_o           (rxd),
      .rx_dv_o         (dv),
      .rx_er_o         (er),
      .false_carrier_o (fc),
      .premature_end_o (pe)
   );

   function automatic logic [4:0] enc(input logic [3:0] n);
      case (n)
         4'h0: enc = 5'b11110;  4'h1: enc = 5'b01001;
         4'h2: enc = 5'b10100;  4'h3: enc = 5'b10101;
         4'h4: enc = 5'b01010;  4'h5: enc = 5'b01011;
         4'h6: enc = 5'b01110;  4'h7: enc = 5'b01111;
         4'h8: enc = 5'b10010;  4'h9: enc = 5'b10011;
         4'hA: enc = 5'b10110;  4'hB: enc = 5'b10111;
         4'hC: enc = 5'b11010;  4'hD: enc = 5'b11011;
         4'hE: enc = 5'b11100;  default: enc = 5'b11101;
      endcase
   endfunction

   task automatic check(input bit ok, input string tag, input string what,
                        input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_errors++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
      end
   endtask

   // driver: present one code group and queue its expected output
   task automatic drive(input logic [4:0] s, input logic edv, input logic eer,
                        input logic [3:0] ed, input string tag);
      exp_t e;
      @(negedge clk);
      code = s;
      e.dv = edv; e.er = eer; e.d = ed; e.tag = tag;
      q.push_back(e);
   endtask

   task automatic idles(input int n);
      for (int i = 0; i < n; i++) drive(5'b11111, 1'b0, 1'b0, 4'h0, "R4");
   endtask

   task automatic ssd();
      drive(5'b11000, 1'b1, 1'b0, 4'b0101, "R3");
      drive(5'b10001, 1'b1, 1'b0, 4'b0101, "R3");
   endtask

   task automatic esd();
      drive(5'b01101, 1'b0, 1'b0, 4'h0, "R5");
      drive(5'b00111, 1'b0, 1'b0, 4'h0, "R5");
   endtask

   task automatic dat(input logic [3:0] n);
      drive(enc(n), 1'b1, 1'b0, n, "R2");
   endtask

   // monitor: output for a symbol is due two edges after it is driven (R10)
   always @(posedge clk) begin
      #2;
      if (mon_en && q.size() >= 2) begin
         exp_t e;
         e = q.pop_front();
         check(dv == e.dv, e.tag, "rx_dv", dv, e.dv);
         check(er == e.er, e.tag, "rx_er", er, e.er);
         check(rxd == e.d, e.tag, "rxd", rxd, e.d);
      end
   end

   initial begin
      #1_000_000;
      n_errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      check(dv == 1'b0 && er == 1'b0 && rxd == 4'h0, "R1", "outputs in reset",
            {dv, er, rxd}, 0);
      check(fc == 1'b0 && pe == 1'b0, "R1", "status in reset", {fc, pe}, 0);
      rst_n = 1'b1;
      mon_en = 1'b1;
      idles(4);

      // full nibble table inside one frame
      ssd();
      for (int n = 0; n < 16; n++) dat(4'(n));
      esd();
      // back-to-back frame right after the end delimiter
      ssd();
      dat(4'h5); dat(4'hA);
      esd();
      idles(3);
      check(fc == 1'b0 && pe == 1'b0, "R5", "status after clean frames", {fc, pe}, 0);

      // in-frame errors that keep the frame open
      ssd();
      dat(4'h3);
      drive(5'b00000, 1'b1, 1'b1, 4'h0, "R6");
      dat(4'hC);
      drive(5'b11111, 1'b1, 1'b1, 4'h0, "R6");
      dat(4'h7);
      drive(5'b01101, 1'b1, 1'b1, 4'h0, "R6");
      dat(4'h9);
      drive(5'b11000, 1'b1, 1'b1, 4'h0, "R6");
      dat(4'h1);
      esd();
      idles(3);
      check(fc == 1'b0 && pe == 1'b0, "R6", "status after in-frame errors", {fc, pe}, 0);

      // false carrier: first half of start delimiter, then a wrong group
      drive(5'b11000, 1'b0, 1'b1, 4'b1110, "R7");
      drive(5'b00100, 1'b0, 1'b1, 4'b1110, "R7");
      drive(5'b10110, 1'b0, 1'b1, 4'b1110, "R7");
      idles(3);
      check(fc == 1'b1, "R7", "false carrier latched", fc, 1);
      check(pe == 1'b0, "R8", "premature end still clear", pe, 0);

      // premature end
      ssd();
      dat(4'hE); dat(4'h2);
      drive(5'b11111, 1'b0, 1'b1, 4'h0, "R8");
      idles(4);
      check(pe == 1'b1, "R8", "premature end latched", pe, 1);
      check(fc == 1'b1, "R9", "false carrier held", fc, 1);

      // clear pulse
      @(negedge clk); clr = 1'b1;
      code = 5'b11111; q.push_back('{1'b0, 1'b0, 4'h0, "R4"});
      @(negedge clk); clr = 1'b0;
      code = 5'b11111; q.push_back('{1'b0, 1'b0, 4'h0, "R4"});
      check(fc == 1'b0 && pe == 1'b0, "R9", "status cleared", {fc, pe}, 0);

      // false carrier from a data group, clear on the same edge as the event
      drive(5'b01010, 1'b0, 1'b1, 4'b1110, "R7");
      @(negedge clk); clr = 1'b1;
      code = 5'b11111; q.push_back('{1'b0, 1'b0, 4'h0, "R7"});
      @(negedge clk); clr = 1'b0;
      code = 5'b11111; q.push_back('{1'b0, 1'b0, 4'h0, "R4"});
      check(fc == 1'b1, "R9", "event beats same-edge clear", fc, 1);
      check(pe == 1'b0, "R9", "clear alone on other bit", pe, 0);
      idles(4);

      mon_en = 1'b0;
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   end

endmodule